// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block turns one range maintenance command into a stream of per-line requests to a cache. A command carries an operation code, a start address, an end address and the address of the instruction that launched it. The sequencer rounds both addresses down to their 32-byte line, then walks upward one line at a time. For each line it presents a request with a line-aligned address and the operation, and it waits for the cache to accept that request before moving on. When the cache accepts the last line, the sequencer pulses done.

Invalidate, clean and clean+invalidate ranges are blocking. An interrupt ends such a range and reports a restart address four bytes past the launching instruction, so the whole range is issued again after the handler returns. A translation fault on a blocking range ends it with an abort pulse that carries the address of the faulting line. Prefetch ranges run in the background. A stop command or a new range cancels them, a fault ends them without any report, and a status bit shows that one is in progress.

Top module: `cache_range_seq`

## Requirements
- R1: The sequencer requests every line from the line holding the start address to the line holding the end address, both included, in increasing order. `line_addr_o` carries bits 31:5 of the line address with bits 4:0 zero. `line_op_o` repeats the command's code: 0 invalidate instruction, 1 invalidate data, 2 clean data, 3 clean+invalidate data, 4 prefetch instruction, 5 prefetch data.
- R2: If the start line is above the end line, no line request, no done pulse and no busy indication follow.
- R3: While the cache does not accept a request, the request stays asserted and its address and operation stay unchanged.
- R4: One cycle after the cache accepts the last line, `done_o` is high for exactly one cycle and the request drops.
- R5: `busy_o` is 1 exactly while a prefetch range (codes 4 and 5) is in progress. It is 0 while a blocking range runs and 0 after reset.
- R6: A start command arriving while a prefetch range runs abandons that range and begins the new one. A start command arriving while a blocking range runs is ignored.
- R7: A stop-prefetch command ends a running prefetch range without a done pulse. It has no effect on a blocking range.
- R8: A fault during a prefetch range ends the range with no abort pulse and no done pulse.
- R9: A fault during a blocking range ends it. `abort_o` pulses for one cycle, and `abort_addr_o` holds the line address that was being requested.
- R10: An interrupt during a blocking range ends it. `restart_o` pulses for one cycle, and `restart_pc_o` equals the launching instruction address plus 4. An interrupt during a prefetch range has no effect.
- R11: A start command with code 6 or 7 is ignored, whether the sequencer is idle or running.
- R12: After reset, the request, busy, done, abort and restart outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| start_i | input | 1 | Start a range command this cycle |
| start_op_i | input | 3 | Operation code of the command |
| start_addr_i | input | 32 | First address of the range |
| end_addr_i | input | 32 | Last address of the range |
| launch_pc_i | input | 32 | Address of the instruction that issued the command |
| stop_pf_i | input | 1 | Cancel a running prefetch range |
| line_ack_i | input | 1 | The cache accepts the current line request |
| fault_i | input | 1 | The current line request met a translation fault |
| irq_i | input | 1 | Interrupt request |
| line_req_o | output | 1 | A line request is presented |
| line_addr_o | output | 32 | Line-aligned address of the request |
| line_op_o | output | 3 | Operation code of the request |
| busy_o | output | 1 | A prefetch range is in progress |
| done_o | output | 1 | One-cycle pulse when the last line has been accepted |
| abort_o | output | 1 | One-cycle pulse on a fault in a blocking range |
| abort_addr_o | output | 32 | Line address that faulted |
| restart_o | output | 1 | One-cycle pulse when an interrupt ends a blocking range |
| restart_pc_o | output | 32 | Launching instruction address plus 4 |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 32-byte lines and a restart step of 4. With these values, ranges of one to sixteen lines can be compared directly against hand-computed line addresses. Ranges whose unaligned start and end bits must be discarded are within reach, and so is a range that sits inside a single line. The same configuration places cancellation, pre-emption, faults and interrupts at chosen line positions within a short walk, and it covers a restart address whose carry crosses a nibble boundary.

// File: rtl/cache_range_pkg.sv
package cache_range_pkg;

  typedef enum logic [2:0] {
    OP_INV_I    = 3'd0,
    OP_INV_D    = 3'd1,
    OP_CLN_D    = 3'd2,
    OP_CLNINV_D = 3'd3,
    OP_PF_I     = 3'd4,
    OP_PF_D     = 3'd5
  } rng_op_e;

  typedef struct packed {
    logic valid;
    logic prefetch;
  } op_class_t;

endpackage

// File: rtl/crs_op_decode.sv
module crs_op_decode
  import cache_range_pkg::*;
(
  input  logic [2:0] op_i,
  output op_class_t  cls_o
);

  always_comb begin
    cls_o = '0;
    case (op_i)
      OP_INV_I, OP_INV_D, OP_CLN_D, OP_CLNINV_D: cls_o.valid = 1'b1;
      OP_PF_I, OP_PF_D: begin
        cls_o.valid    = 1'b1;
        cls_o.prefetch = 1'b1;
      end
      default: cls_o = '0;
    endcase
  end

endmodule

// File: rtl/crs_line_walker.sv
module crs_line_walker #(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic [LINE_W-1:0] end_line_i,
  input  logic              step_i,
  output logic [LINE_W-1:0] cur_line_o,
  output logic [LINE_W-1:0] end_line_o,
  output logic              last_o,
  output logic              empty_o
);

  logic [LINE_W-1:0] cur_q, cur_d;
  logic [LINE_W-1:0] end_q, end_d;
  logic              cur_en;

  assign empty_o = start_line_i > end_line_i;

  always_comb begin
    cur_en = load_i | step_i;
    cur_d  = cur_q;
    end_d  = end_q;
    if (load_i) begin
      cur_d = start_line_i;
      end_d = end_line_i;
    end else if (step_i) begin
      cur_d = cur_q + LINE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      end_q <= '0;
    end else if (cur_en) begin
      cur_q <= cur_d;
      end_q <= end_d;
    end
  end

  assign cur_line_o = cur_q;
  assign end_line_o = end_q;
  assign last_o     = cur_q == end_q;

endmodule

// File: rtl/crs_ctrl.sv
module crs_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 5,
  parameter int PC_STEP  = 4,
  localparam int LINE_W  = ADDR_W - LINE_OFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [2:0]             op_i,
  input  logic [ADDR_W-1:0]      launch_pc_i,
  input  cache_range_pkg::op_class_t cls_i,
  input  logic                   empty_i,
  input  logic                   stop_pf_i,
  input  logic                   line_ack_i,
  input  logic                   fault_i,
  input  logic                   irq_i,
  input  logic [LINE_W-1:0]      cur_line_i,
  input  logic                   last_i,
  output logic                   load_o,
  output logic                   step_o,
  output logic                   walk_o,
  output logic [2:0]             op_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   abort_o,
  output logic [ADDR_W-1:0]      abort_addr_o,
  output logic                   restart_o,
  output logic [ADDR_W-1:0]      restart_pc_o
);

  logic              walk_q, walk_d;
  logic              pf_q, pf_d;
  logic [2:0]        op_q, op_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              cmd_en;
  logic              done_q, done_d;
  logic              abort_q, abort_d;
  logic              restart_q, restart_d;
  logic [ADDR_W-1:0] abort_addr_q, abort_addr_d;
  logic [ADDR_W-1:0] restart_pc_q, restart_pc_d;
  logic              abort_en, restart_en;
  logic              accept;

  // A new command is taken when idle or when it pre-empts a prefetch.
  assign accept = start_i && cls_i.valid && (!walk_q || pf_q);

  always_comb begin
    walk_d       = walk_q;
    pf_d         = pf_q;
    op_d         = op_q;
    pc_d         = pc_q;
    cmd_en       = 1'b0;
    load_o       = 1'b0;
    step_o       = 1'b0;
    done_d       = 1'b0;
    abort_d      = 1'b0;
    restart_d    = 1'b0;
    abort_en     = 1'b0;
    restart_en   = 1'b0;
    abort_addr_d = {cur_line_i, {LINE_OFF{1'b0}}};
    restart_pc_d = pc_q + ADDR_W'(PC_STEP);
    if (accept) begin
      cmd_en = 1'b1;
      walk_d = !empty_i;
      load_o = !empty_i;
      pf_d   = cls_i.prefetch;
      op_d   = op_i;
      pc_d   = launch_pc_i;
    end else if (walk_q) begin
      if (pf_q) begin
        if (stop_pf_i || fault_i) begin
          walk_d = 1'b0;
        end else if (line_ack_i) begin
          if (last_i) begin
            walk_d = 1'b0;
            done_d = 1'b1;
          end else begin
            step_o = 1'b1;
          end
        end
      end else begin
        if (irq_i) begin
          walk_d     = 1'b0;
          restart_d  = 1'b1;
          restart_en = 1'b1;
        end else if (fault_i) begin
          walk_d   = 1'b0;
          abort_d  = 1'b1;
          abort_en = 1'b1;
        end else if (line_ack_i) begin
          if (last_i) begin
            walk_d = 1'b0;
            done_d = 1'b1;
          end else begin
            step_o = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_q    <= 1'b0;
      done_q    <= 1'b0;
      abort_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      walk_q    <= walk_d;
      done_q    <= done_d;
      abort_q   <= abort_d;
      restart_q <= restart_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      op_q <= '0;
      pc_q <= '0;
    end else if (cmd_en) begin
      pf_q <= pf_d;
      op_q <= op_d;
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_addr_q <= '0;
    end else if (abort_en) begin
      abort_addr_q <= abort_addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_pc_q <= '0;
    end else if (restart_en) begin
      restart_pc_q <= restart_pc_d;
    end
  end

  assign walk_o       = walk_q;
  assign op_o         = op_q;
  assign busy_o       = walk_q && pf_q;
  assign done_o       = done_q;
  assign abort_o      = abort_q;
  assign abort_addr_o = abort_addr_q;
  assign restart_o    = restart_q;
  assign restart_pc_o = restart_pc_q;

  // R4 / R9 / R10: at most one completion event per cycle
  a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, abort_q, restart_q}));

  // R8 / R9: an abort only follows a blocking walk
  a_r9_abort_blocking_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_q) |-> $past(walk_q && !pf_q));

  // R10: a restart leaves the sequencer idle
  a_r10_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> !walk_q);

  // R7: stop ends a running prefetch
  a_r7_stop_ends_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_q && pf_q && stop_pf_i && !start_i) |=> !walk_q);

  // R6: a blocking walk keeps its operation despite new commands
  a_r6_blocking_keeps_op: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_q && !pf_q && walk_d) |=> $stable(op_q));

endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq
  import cache_range_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PC_STEP    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        start_op_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [ADDR_W-1:0] launch_pc_i,
  input  logic              stop_pf_i,
  input  logic              line_ack_i,
  input  logic              fault_i,
  input  logic              irq_i,
  output logic              line_req_o,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic [2:0]        line_op_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              abort_o,
  output logic [ADDR_W-1:0] abort_addr_o,
  output logic              restart_o,
  output logic [ADDR_W-1:0] restart_pc_o
);

  localparam int LINE_OFF = $clog2(LINE_BYTES);
  localparam int LINE_W   = ADDR_W - LINE_OFF;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  op_class_t         cls;
  logic              load, step, walk, last, empty;
  logic [LINE_W-1:0] cur_line, end_line;

  crs_op_decode u_dec (
    .op_i  (start_op_i),
    .cls_o (cls)
  );

  crs_line_walker #(.LINE_W(LINE_W)) u_walk (
    .clk          (clk),
    .rst_n        (rst_ni),
    .load_i       (load),
    .start_line_i (start_addr_i[ADDR_W-1:LINE_OFF]),
    .end_line_i   (end_addr_i[ADDR_W-1:LINE_OFF]),
    .step_i       (step),
    .cur_line_o   (cur_line),
    .end_line_o   (end_line),
    .last_o       (last),
    .empty_o      (empty)
  );

  crs_ctrl #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .PC_STEP(PC_STEP)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_ni),
    .start_i      (start_i),
    .op_i         (start_op_i),
    .launch_pc_i  (launch_pc_i),
    .cls_i        (cls),
    .empty_i      (empty),
    .stop_pf_i    (stop_pf_i),
    .line_ack_i   (line_ack_i),
    .fault_i      (fault_i),
    .irq_i        (irq_i),
    .cur_line_i   (cur_line),
    .last_i       (last),
    .load_o       (load),
    .step_o       (step),
    .walk_o       (walk),
    .op_o         (line_op_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .abort_o      (abort_o),
    .abort_addr_o (abort_addr_o),
    .restart_o    (restart_o),
    .restart_pc_o (restart_pc_o)
  );

  assign line_req_o  = walk;
  assign line_addr_o = {cur_line, {LINE_OFF{1'b0}}};

  // R1 / R2: an active walk never passes its end line
  a_r1_within_range: assert property (@(posedge clk) disable iff (!rst_ni)
    walk |-> (cur_line <= end_line));

  // R3: without acceptance or another event the request holds its address
  a_r3_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    (walk && !line_ack_i && !fault_i && !irq_i && !start_i && !stop_pf_i)
      |=> (line_req_o && $stable(line_addr_o)));

  // R5: busy only while a request is presented
  a_r5_busy_with_req: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o |-> line_req_o);

endmodule

// File: tb/test_cache_range_seq.sv
module test_cache_range_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, stop_pf_i, line_ack_i, fault_i, irq_i;
  logic [2:0]  start_op_i;
  logic [31:0] start_addr_i, end_addr_i, launch_pc_i;
  logic        line_req_o, busy_o, done_o, abort_o, restart_o;
  logic [31:0] line_addr_o, abort_addr_o, restart_pc_o;
  logic [2:0]  line_op_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  cache_range_seq i_cache_range_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_op_i(start_op_i),
    .start_addr_i(start_addr_i), .end_addr_i(end_addr_i), .launch_pc_i(launch_pc_i),
    .stop_pf_i(stop_pf_i), .line_ack_i(line_ack_i), .fault_i(fault_i), .irq_i(irq_i),
    .line_req_o(line_req_o), .line_addr_o(line_addr_o), .line_op_o(line_op_o),
    .busy_o(busy_o), .done_o(done_o), .abort_o(abort_o), .abort_addr_o(abort_addr_o),
    .restart_o(restart_o), .restart_pc_o(restart_pc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [31:0] s, input logic [31:0] e,
                     input logic [31:0] pc);
    start_i = 1'b1; start_op_i = op; start_addr_i = s; end_addr_i = e; launch_pc_i = pc;
    tick();
    start_i = 1'b0;
  endtask

  task automatic ack();
    line_ack_i = 1'b1;
    tick();
    line_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 req", line_req_o, 0);
    chk("R12 busy", busy_o, 0);
    chk("R12 done", done_o, 0);
    chk("R12 abort", abort_o, 0);
    chk("R12 restart", restart_o, 0);
  endtask

  task automatic t_walk();
    cmd(3'd2, 32'h1000_0013, 32'h1000_0070, 32'h0);
    for (int i = 0; i < 4; i++) begin
      chk("R1 req", line_req_o, 1);
      chk("R1 addr", line_addr_o, 32'h1000_0000 + 32'(i) * 32);
      chk("R1 op", line_op_o, 2);
      chk("R5 busy blocking", busy_o, 0);
      if (i == 1) begin
        tick();
        chk("R3 hold req", line_req_o, 1);
        chk("R3 hold addr", line_addr_o, 32'h1000_0020);
      end
      ack();
    end
    chk("R4 done", done_o, 1);
    chk("R4 req drops", line_req_o, 0);
    tick();
    chk("R4 done single", done_o, 0);
  endtask

  task automatic t_empty();
    cmd(3'd1, 32'h0000_0200, 32'h0000_01E0, 32'h0);
    chk("R2 no req", line_req_o, 0);
    tick();
    chk("R2 no done", done_o, 0);
    chk("R2 no busy", busy_o, 0);
    cmd(3'd1, 32'h0000_0205, 32'h0000_021F, 32'h0);
    chk("R1 single line", line_addr_o, 32'h0000_0200);
    ack();
    chk("R4 single done", done_o, 1);
  endtask

  task automatic t_prefetch_stop();
    cmd(3'd5, 32'h0, 32'h3E0, 32'h0);
    chk("R5 busy pf", busy_o, 1);
    chk("R1 pf op", line_op_o, 5);
    ack(); ack();
    chk("R1 pf addr", line_addr_o, 32'h40);
    irq_i = 1'b1; tick(); irq_i = 1'b0;
    chk("R10 irq ignored pf", line_req_o, 1);
    chk("R10 no restart pf", restart_o, 0);
    stop_pf_i = 1'b1; tick(); stop_pf_i = 1'b0;
    chk("R7 stop req", line_req_o, 0);
    chk("R7 stop busy", busy_o, 0);
    chk("R7 no done", done_o, 0);
  endtask

  task automatic t_preempt();
    cmd(3'd4, 32'h800, 32'hFE0, 32'h0);
    cmd(3'd6, 32'h100, 32'h120, 32'h0);
    chk("R11 op6 ignored addr", line_addr_o, 32'h800);
    chk("R11 op6 ignored busy", busy_o, 1);
    cmd(3'd0, 32'h400, 32'h420, 32'h0);
    chk("R6 preempt addr", line_addr_o, 32'h400);
    chk("R6 preempt op", line_op_o, 0);
    chk("R6 preempt busy", busy_o, 0);
    cmd(3'd3, 32'h9000, 32'h9020, 32'h0);
    chk("R6 blocking ignores start", line_addr_o, 32'h400);
    chk("R6 blocking op kept", line_op_o, 0);
    stop_pf_i = 1'b1; tick(); stop_pf_i = 1'b0;
    chk("R7 stop no effect", line_req_o, 1);
    ack(); ack();
    chk("R6 done", done_o, 1);
  endtask

  task automatic t_faults();
    cmd(3'd4, 32'h2000, 32'h2080, 32'h0);
    ack();
    fault_i = 1'b1; tick(); fault_i = 1'b0;
    chk("R8 pf fault ends", line_req_o, 0);
    chk("R8 pf no abort", abort_o, 0);
    chk("R8 pf no done", done_o, 0);
    cmd(3'd3, 32'h3000, 32'h30C0, 32'h0);
    ack(); ack();
    fault_i = 1'b1; tick(); fault_i = 1'b0;
    chk("R9 abort", abort_o, 1);
    chk("R9 abort addr", abort_addr_o, 32'h3040);
    chk("R9 req drops", line_req_o, 0);
    tick();
    chk("R9 abort pulse", abort_o, 0);
  endtask

  task automatic t_irq();
    cmd(3'd1, 32'h5000, 32'h5100, 32'h0000_0FFC);
    ack();
    irq_i = 1'b1; tick(); irq_i = 1'b0;
    chk("R10 restart", restart_o, 1);
    chk("R10 restart pc", restart_pc_o, 32'h0000_1000);
    chk("R10 req drops", line_req_o, 0);
    tick();
    chk("R10 restart pulse", restart_o, 0);
  endtask

  task automatic t_bad_op();
    cmd(3'd7, 32'h0, 32'h100, 32'h0);
    chk("R11 op7 idle", line_req_o, 0);
    chk("R11 op7 busy", busy_o, 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 0; stop_pf_i = 0; line_ack_i = 0; fault_i = 0; irq_i = 0;
    start_op_i = 0; start_addr_i = 0; end_addr_i = 0; launch_pc_i = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_walk();
    t_empty();
    t_prefetch_stop();
    t_preempt();
    t_faults();
    t_irq();
    t_bad_op();
    finish_run();
  end

endmodule